// File: doc/BRIEF.md
# Raster Panel Timing Generator

This block produces the timing for a parallel TFT panel. It divides the core clock down to a pixel-rate enable and a pixel clock waveform. It then counts pixels within a line and lines within a frame, and drives horizontal sync, vertical sync, a data-enable window, and strobes that mark the first pixel of each line and of each frame. Pixel data is produced elsewhere. The data path uses `pix_ce` to advance and `data_en` to know when a pixel is visible.

Four 32-bit configuration words arrive on input ports. Each field keeps the bit position that its decoder expects: the divisor, the horizontal timing, the vertical timing, and the polarity and extension word. A single enable input starts the raster. The block copies every field into shadow registers at the start of each frame, so software may rewrite the words while a frame is being scanned. Clearing the enable lets the current frame finish, and the counters then stay idle.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the block is idle: `pix_ce`, `data_en`, `line_start` and `frame_start` are 0. While idle, `pix_clk`, `hsync` and `vsync` sit at their inactive levels, which are the live values of `tim2_word` bits 22, 21 and 20 respectively.
- R2: While running, `pix_ce` is high for one core cycle out of every D, where D is `ctrl_word[15:8]` and the values 0 and 1 act as 2. The first pulse falls in the D-th core cycle after the clock edge that starts the raster.
- R3: Within each pixel period of D core cycles, `pix_clk` is high for the first floor(D/2) cycles and low for the rest. Setting `tim2_word` bit 22 inverts the whole waveform.
- R4: A line lasts (HS+1)+(HB+1)+16*(PPL+1)+(HF+1) pixel periods. PPL is {`tim0_word[3]`, `tim0_word[9:4]`}, HS is `tim0_word[15:10]`, HF is `tim0_word[23:16]` and HB is `tim0_word[31:24]`.
- R5: A line runs in this order: sync for HS+1 pixels, back porch, active pixels, front porch. `hsync` is high during the sync part unless `tim2_word` bit 21 inverts it.
- R6: A frame runs in the same order over lines: VS+1 sync lines, VB+1 back porch lines, LPP+1 active lines, then VF+1 front porch lines. LPP is {`tim2_word[26]`, `tim1_word[9:0]`}, and VS, VF and VB sit in `tim1_word` at the same positions as their horizontal counterparts in `tim0_word`. `vsync` is high during the sync lines unless `tim2_word` bit 20 inverts it.
- R7: `data_en` is high exactly when both the pixel and the line lie in their active regions.
- R8: `line_start` pulses together with the `pix_ce` that ends the first pixel of every line. `frame_start` pulses only with the `line_start` of line 0.
- R9: Configuration words are copied at frame start only. Changing them in the middle of a frame has no effect on that frame, and the new values take effect from the next frame.
- R10: `raster_en` is looked at only while idle and on the last pixel of a frame. If it is low at the end of a frame, the frame completes and the block returns to idle. If it is high, the next frame follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raster_en | input | 1 | Starts the raster, or keeps it running |
| ctrl_word | input | 32 | Pixel clock divisor in bits 15:8 |
| tim0_word | input | 32 | Horizontal timing fields |
| tim1_word | input | 32 | Vertical timing fields and low line-count bits |
| tim2_word | input | 32 | Polarity inverts and line-count bit 10 |
| pix_ce | output | 1 | One-cycle pixel advance enable |
| pix_clk | output | 1 | Divided pixel clock waveform |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| data_en | output | 1 | Visible pixel window |
| line_start | output | 1 | First pixel of a line |
| frame_start | output | 1 | First pixel of a frame |

## Verification
The bench targets the following corner cases:
- **Divisor values 0 and 1.** A design that did not clamp them would emit `pix_ce` on every cycle, and `pix_clk` would stop toggling.
- **Configuration rewritten mid-frame, and enable dropped mid-frame.** A design that read the live words would bend the current line or frame. A design that obeyed the enable at once would cut the frame short.
- **Top line-width bit and top line-count bit.** A design that dropped either one would produce a line or frame shorter by 1024 pixels or lines.
- **Polarity bits while idle and while running.** The bench checks these because a swapped invert would show the wrong idle level.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int DIV_W       = 8,
  parameter bit WIDE_LAYOUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        raster_en,
  input  logic [31:0] ctrl_word,
  input  logic [31:0] tim0_word,
  input  logic [31:0] tim1_word,
  input  logic [31:0] tim2_word,
  output logic        pix_ce,
  output logic        pix_clk,
  output logic        hsync,
  output logic        vsync,
  output logic        data_en,
  output logic        line_start,
  output logic        frame_start
);

  localparam int PPL_W = WIDE_LAYOUT ? 7 : 6;
  localparam int LPP_W = WIDE_LAYOUT ? 11 : 10;
  localparam int H_MAX = 576 + 16 * (1 << PPL_W);
  localparam int V_MAX = 576 + (1 << LPP_W);
  localparam int H_W   = $clog2(H_MAX + 1);
  localparam int V_W   = $clog2(V_MAX + 1);

  logic [PPL_W-1:0] ppl_in;
  logic [LPP_W-1:0] lpp_in;

  generate
    if (WIDE_LAYOUT) begin : g_wide
      assign ppl_in = {tim0_word[3], tim0_word[9:4]};
      assign lpp_in = {tim2_word[26], tim1_word[9:0]};
    end else begin : g_narrow
      assign ppl_in = tim0_word[9:4];
      assign lpp_in = tim1_word[9:0];
    end
  endgenerate

  logic unused_cfg;
  assign unused_cfg = ^{ctrl_word, tim0_word[3:0], tim2_word};

  logic             running;
  logic [DIV_W-1:0] divcnt;
  logic [H_W-1:0]   hcnt;
  logic [V_W-1:0]   vcnt;

  logic [DIV_W-1:0] s_div;
  logic [PPL_W-1:0] s_ppl;
  logic [LPP_W-1:0] s_lpp;
  logic [5:0]       s_hsw, s_vsw;
  logic [7:0]       s_hbp, s_hfp, s_vbp, s_vfp;
  logic [2:0]       s_inv;

  logic [DIV_W-1:0] d_last, d_half;
  logic [H_W-1:0]   h_act_beg, h_act_end, h_last;
  logic [V_W-1:0]   v_act_beg, v_act_end, v_last;
  logic             tick, line_end, frame_end, load;
  logic [2:0]       inv_now;

  assign d_last    = (s_div < DIV_W'(2)) ? DIV_W'(1) : s_div - DIV_W'(1);
  assign d_half    = (s_div < DIV_W'(2)) ? DIV_W'(1) : (s_div >> 1);

  assign h_act_beg = H_W'(s_hsw) + H_W'(s_hbp) + H_W'(2);
  assign h_act_end = h_act_beg + ((H_W'(s_ppl) + H_W'(1)) << 4);
  assign h_last    = h_act_end + H_W'(s_hfp);
  assign v_act_beg = V_W'(s_vsw) + V_W'(s_vbp) + V_W'(2);
  assign v_act_end = v_act_beg + V_W'(s_lpp) + V_W'(1);
  assign v_last    = v_act_end + V_W'(s_vfp);

  assign tick      = running && (divcnt == d_last);
  assign line_end  = tick && (hcnt == h_last);
  assign frame_end = line_end && (vcnt == v_last);
  assign load      = raster_en && (!running || frame_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      divcnt  <= '0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (!running) begin
      divcnt  <= '0;
      hcnt    <= '0;
      vcnt    <= '0;
      running <= raster_en;
    end else if (tick) begin
      divcnt <= '0;
      if (line_end) begin
        hcnt <= '0;
        if (frame_end) begin
          vcnt    <= '0;
          running <= raster_en;
        end else begin
          vcnt <= vcnt + V_W'(1);
        end
      end else begin
        hcnt <= hcnt + H_W'(1);
      end
    end else begin
      divcnt <= divcnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_div <= '0; s_ppl <= '0; s_lpp <= '0;
      s_hsw <= '0; s_hbp <= '0; s_hfp <= '0;
      s_vsw <= '0; s_vbp <= '0; s_vfp <= '0;
      s_inv <= '0;
    end else if (load) begin
      s_div <= ctrl_word[8 +: DIV_W];
      s_ppl <= ppl_in;
      s_lpp <= lpp_in;
      s_hsw <= tim0_word[15:10];
      s_hfp <= tim0_word[23:16];
      s_hbp <= tim0_word[31:24];
      s_vsw <= tim1_word[15:10];
      s_vfp <= tim1_word[23:16];
      s_vbp <= tim1_word[31:24];
      s_inv <= tim2_word[22:20];
    end
  end

  assign inv_now     = running ? s_inv : tim2_word[22:20];
  assign pix_ce      = tick;
  assign pix_clk     = (running && (divcnt < d_half)) ^ inv_now[2];
  assign hsync       = (running && (hcnt <= H_W'(s_hsw))) ^ inv_now[1];
  assign vsync       = (running && (vcnt <= V_W'(s_vsw))) ^ inv_now[0];
  assign data_en     = running && (hcnt >= h_act_beg) && (hcnt < h_act_end)
                               && (vcnt >= v_act_beg) && (vcnt < v_act_end);
  assign line_start  = tick && (hcnt == '0);
  assign frame_start = line_start && (vcnt == '0);

  a_r2_ce_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> !pix_ce);

  a_r4_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (hcnt <= h_last) && (vcnt <= v_last));

  a_r7_de_off_sync: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> (hsync == s_inv[1]) && (vsync == s_inv[0]));

  a_r8_frame_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start && pix_ce);

  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !frame_end) |=> $stable({s_div, s_ppl, s_lpp, s_hsw, s_hbp,
                                         s_hfp, s_vsw, s_vbp, s_vfp, s_inv}));

  a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !raster_en) |=> !running);

  a_r10_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && raster_en) |=> running);

endmodule

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;

  typedef struct packed {
    logic [31:0] c;
    logic [31:0] t0;
    logic [31:0] t1;
    logic [31:0] t2;
  } cfg_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [31:0] rc, r0, r1, r2;
  logic        pix_ce, pix_clk, hsync, vsync, data_en, line_start, frame_start;

  int unsigned vecs = 0;
  int unsigned bad  = 0;
  int unsigned cyc  = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  raster_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .raster_en(en),
    .ctrl_word(rc), .tim0_word(r0), .tim1_word(r1), .tim2_word(r2),
    .pix_ce(pix_ce), .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync),
    .data_en(data_en), .line_start(line_start), .frame_start(frame_start)
  );

  wire [6:0] act = {pix_ce, pix_clk, hsync, vsync, data_en, line_start, frame_start};

  function automatic cfg_t mk(int dv, int ppl6, bit w3, int hsw, int hbp, int hfp,
                              int lpp10, bit b26, int vsw, int vbp, int vfp, logic [2:0] inv);
    cfg_t x;
    x.c  = {16'h0, 8'(dv), 8'h0};
    x.t0 = {8'(hbp), 8'(hfp), 6'(hsw), 6'(ppl6), w3, 3'b0};
    x.t1 = {8'(vbp), 8'(vfp), 6'(vsw), 10'(lpp10)};
    x.t2 = {5'b0, b26, 3'b0, inv, 20'h0};
    return x;
  endfunction

  function automatic int f_div(cfg_t x);
    int d = int'(x.c[15:8]);
    return (d < 2) ? 2 : d;
  endfunction
  function automatic int f_hact(cfg_t x);
    return 16 * (int'({x.t0[3], x.t0[9:4]}) + 1);
  endfunction
  function automatic int f_htot(cfg_t x);
    return int'(x.t0[15:10]) + int'(x.t0[31:24]) + int'(x.t0[23:16]) + 3 + f_hact(x);
  endfunction
  function automatic int f_lines(cfg_t x);
    return int'({x.t2[26], x.t1[9:0]}) + 1;
  endfunction
  function automatic int f_vtot(cfg_t x);
    return int'(x.t1[15:10]) + int'(x.t1[31:24]) + int'(x.t1[23:16]) + 3 + f_lines(x);
  endfunction
  function automatic int f_ftot(cfg_t x);
    return f_htot(x) * f_vtot(x) * f_div(x);
  endfunction

  function automatic logic [6:0] expect_at(cfg_t x, int k);
    int d   = f_div(x);
    int per = k % d;
    int idx = k / d;
    int h   = idx % f_htot(x);
    int v   = idx / f_htot(x);
    int hb  = int'(x.t0[15:10]) + int'(x.t0[31:24]) + 2;
    int vb  = int'(x.t1[15:10]) + int'(x.t1[31:24]) + 2;
    logic ce, pc, hs, vs, de, ls, fs;
    ce = (per == d - 1);
    pc = (per < d / 2) ^ x.t2[22];
    hs = (h <= int'(x.t0[15:10])) ^ x.t2[21];
    vs = (v <= int'(x.t1[15:10])) ^ x.t2[20];
    de = (h >= hb) && (h < hb + f_hact(x)) && (v >= vb) && (v < vb + f_lines(x));
    ls = ce && (h == 0);
    fs = ls && (v == 0);
    return {ce, pc, hs, vs, de, ls, fs};
  endfunction

  function automatic string bit_tag(int b);
    case (b)
      6: return "R2 pix_ce";
      5: return "R3 pix_clk";
      4: return "R5 hsync";
      3: return "R6 vsync";
      2: return "R7 data_en";
      default: return "R8 strobe";
    endcase
  endfunction

  task automatic chk(logic [6:0] e, string tag, string ctx);
    vecs++;
    if (act !== e) begin
      bad++;
      for (int b = 6; b >= 0; b--)
        if (act[b] !== e[b])
          $display("FAIL %s %s: got %b expected %b (vector %b vs %b)",
                   (tag == "") ? bit_tag(b) : tag, ctx, act[b], e[b], act, e);
    end
  endtask

  task automatic drive(cfg_t x, bit e);
    rc = x.c; r0 = x.t0; r1 = x.t1; r2 = x.t2; en = e;
  endtask

  task automatic begin_raster(cfg_t x);
    drive(x, 1'b1);
    @(posedge clk);
    @(negedge clk);
  endtask

  // R4: line length shows up as the spacing of line_start and of the sync and active windows
  task automatic run_frame(cfg_t cur, cfg_t nxt, bit nxt_en, int mid, string ctx);
    int n = f_ftot(cur);
    for (int k = 0; k < n; k++) begin
      chk(expect_at(cur, k), "", ctx);
      if (k == mid) drive(nxt, nxt_en);  // R9 / R10: new words and enable written mid-frame
      @(negedge clk);
    end
  endtask

  task automatic idle_chk(int n, string tag);
    for (int i = 0; i < n; i++) begin
      chk({1'b0, r2[22], r2[21], r2[20], 3'b000}, tag, "idle");
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      bad++;
      $display("FAIL watchdog: got no finish, expected finish before cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    cfg_t a, b, x;
    void'($urandom(32'd7731));
    rst_n = 1'b0;
    drive('0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(7'b0, "R1", "in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk(2, "R1");
    r2 = 32'h0070_0000;
    @(negedge clk);
    idle_chk(2, "R1");

    a = mk(3, 0, 1'b0, 1, 2, 1, 2, 1'b0, 0, 1, 0, 3'b000);
    b = mk(0, 1, 1'b0, 0, 0, 0, 1, 1'b0, 1, 0, 1, 3'b101);
    begin_raster(a);
    run_frame(a, b, 1'b1, f_ftot(a) / 2, "R9 frame A with B written mid-frame");
    run_frame(b, b, 1'b0, f_ftot(b) / 3, "R10 frame B with enable cleared mid-frame");
    idle_chk(4, "R10");

    b = mk(1, 0, 1'b0, 2, 1, 3, 0, 1'b0, 2, 2, 2, 3'b010);
    begin_raster(b);
    run_frame(b, b, 1'b0, 0, "R2 divisor 1 clamped");
    idle_chk(2, "R10");

    for (int i = 0; i < 14; i++) begin
      x = mk($urandom_range(0, 5), $urandom_range(0, 1), 1'b0,
             $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
             $urandom_range(0, 3), 1'b0,
             $urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 2),
             3'($urandom_range(0, 7)));
      begin_raster(x);
      run_frame(x, x, 1'b0, $urandom_range(0, f_ftot(x) - 1), "random frame");
      idle_chk(3, "R10");
    end

    x = mk(2, 0, 1'b1, 0, 1, 0, 1, 1'b0, 0, 0, 0, 3'b000);
    begin_raster(x);
    run_frame(x, x, 1'b0, 5, "R4 seventh width bit");
    idle_chk(2, "R10");

    x = mk(0, 0, 1'b0, 0, 0, 0, 0, 1'b1, 0, 0, 0, 3'b001);
    begin_raster(x);
    run_frame(x, x, 1'b0, 5, "R6 line count bit 10");
    idle_chk(2, "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule